// File: doc/BRIEF.md
# LCD panel power sequencer

This block walks the timing-generator chip of an LCD panel through its power-up and power-down sequences. Every action reaches the chip as a write on a narrow register port: a 3-bit address, an 8-bit value, a one-cycle valid pulse, and a ready input that the sequencer waits for before it takes the next step. The one exception is the bias-voltage step. For that step the block hands an 8-bit value to an external serial DAC sender over a start/done handshake. Between some steps the sequencer holds for fixed delays that are given as clock-cycle parameters, so that each supply rail can settle.

A power-up request carries a resolution mode, VGA or QVGA. When the panel is not yet initialized, the block runs the full rail bring-up and finishes by setting its `panel_init` flag and writing the resolution register. When the panel is already initialized, the same request only writes the phase and resolution registers. A suspend request first waits two frame times and then takes the rails down in reverse order, finishing by clearing `panel_init`. The phase and bias values come from stored settings, each with its own "not set" flag.

The controller is a single state machine with six states:
- `ST_IDLE` takes a request. A suspend request goes to `ST_STEP` with the down program. A power-up request goes to `ST_STEP` with either the full or the quick program.
- `ST_STEP` decodes the current step:
  - a write goes to `ST_WR_WAIT`;
  - a delay goes to `ST_DELAY`;
  - a bias step goes to `ST_DAC_WAIT`;
  - a flag step stays in `ST_STEP` and advances;
  - the end marker goes to `ST_DONE`.
- `ST_WR_WAIT` returns to `ST_STEP` on ready.
- `ST_DELAY` returns to `ST_STEP` when the timer expires.
- `ST_DAC_WAIT` returns to `ST_STEP` on DAC done.
- `ST_DONE` always returns to `ST_IDLE`.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, `seq_busy`, `panel_init`, `reg_wr_valid`, `dac_start` and `seq_done` are all 0.
- R2: A power-up request with `panel_init` = 0 produces these writes in order, as (address, value):
  - (6,1F), (3,03), (4,00), (4,04)
  - (3,07), (6,09)
  - (3,17), (4,06)
  - (6,01), (3,1F), (4,07), (6,00)
  - (1,phase), (7,00), (0,res)
  
  The bias step comes between (6,09) and (3,17).
- R3: Each delay is at least its parameter, in cycles:
  - from the valid of (4,04) to the next valid, `T_VDD_CYC`;
  - from the valid of (4,06) to the next valid, `T_GVSS_CYC`;
  - from the valid of the polarity write to the resolution write, `T_SETTLE_CYC`;
  - from a suspend request to its first write, `T_FRAME_CYC`.
- R4: Each sequence makes its bias step through exactly one `dac_start` pulse. `dac_value` is held until `dac_done`. The value during power-up is the stored bias, or 125 when `bias_unset` = 1. The value during suspend is 0.
- R5: The phase value (address 1) is:
  - in QVGA mode, 0x13;
  - in VGA mode with `phase_unset` = 1, 0x01;
  - otherwise, `{3'b0, phase_adj[3:0], 1'b1}`.
- R6: The last write of any power-up is address 0, with value 1 when `up_mode_qvga` = 1 (QVGA) and 0 when it is 0 (VGA).
- R7: A power-up request while `panel_init` = 1 produces only (1,phase) then (0,res), with no bias step and no delay.
- R8: A suspend request produces these writes in order:
  - (4,06), (6,08), (3,14)
  - the bias step with value 0
  - (4,04), (3,04), (6,1E), (3,00), (4,00)
- R9: `panel_init` is already 1 when the resolution write of a full power-up is issued, and 0 before it. It drops to 0 at the end of a suspend. It changes only while `seq_busy` = 1.
- R10: `reg_wr_valid` lasts exactly one cycle. No new write is issued until `reg_wr_ready` has been seen high, counting from the cycle after the valid.
- R11: Requests that arrive while `seq_busy` = 1 are ignored. When both requests arrive together in idle, the suspend wins.
- R12: `seq_done` is a one-cycle pulse at the end of each sequence. `seq_busy` is 1 from the cycle after a request is accepted through the `seq_done` cycle, and 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_up_req | input | 1 | Power-up request pulse |
| up_mode_qvga | input | 1 | Resolution for power-up: 1 QVGA, 0 VGA |
| suspend_req | input | 1 | Power-down request pulse |
| phase_adj | input | 4 | Stored phase adjustment |
| phase_unset | input | 1 | Stored phase is absent |
| bias_val | input | 8 | Stored bias code |
| bias_unset | input | 1 | Stored bias is absent |
| reg_wr_valid | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 3 | Register address |
| reg_wr_data | output | 8 | Register value |
| reg_wr_ready | input | 1 | Write accepted by the panel port |
| dac_start | output | 1 | Start pulse to the serial DAC sender |
| dac_value | output | 8 | Bias code for the DAC |
| dac_done | input | 1 | DAC transfer finished |
| panel_init | output | 1 | Panel is powered and initialized |
| seq_busy | output | 1 | A sequence is in progress |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench goes after the following corner cases:

| Corner case | Failure it exposes |
|---|---|
| Power-up into an already initialized panel | A design that ignored the flag would replay the whole rail order instead of two writes. |
| Both requests in the same idle cycle | A design with the wrong priority would start a power-up. |
| Requests injected mid-sequence | A design that queued them would show `seq_busy` again after `seq_done`. |
| Ready and DAC done delayed at random | A design that skipped a handshake would issue writes out of turn or move `dac_value` early. |
| Phase with VGA or QVGA and set or unset stored values | Exposes wrong nibble placement or a missing fallback. |
| Delay gaps measured in cycles | A shortened delay shows up as a gap below the parameter. |

// File: rtl/lcd_seq_pkg.sv
`timescale 1ns/1ps
package lcd_seq_pkg;

    // Register addresses decoded by the timing-generator chip
    localparam logic [2:0] ADR_RES   = 3'd0;
    localparam logic [2:0] ADR_PHASE = 3'd1;
    localparam logic [2:0] ADR_PWR0  = 3'd3;
    localparam logic [2:0] ADR_PWR1  = 3'd4;
    localparam logic [2:0] ADR_IFCTL = 3'd6;
    localparam logic [2:0] ADR_POL   = 3'd7;

    localparam int STEP_IDX_W = 5;

    typedef enum logic [2:0] {
        SK_WRITE,
        SK_WAIT,
        SK_DAC,
        SK_SETF,
        SK_CLRF,
        SK_END
    } step_kind_e;

    typedef enum logic [1:0] {
        SQ_FULL,
        SQ_QUICK,
        SQ_DOWN
    } seq_sel_e;

    typedef enum logic [1:0] {
        WT_VDD,
        WT_GVSS,
        WT_SETTLE,
        WT_FRAME
    } wait_sel_e;

    typedef struct packed {
        step_kind_e kind;
        logic [2:0] addr;
        logic [7:0] data;
        wait_sel_e  wsel;
    } step_t;

    function automatic step_t mk_wr(input logic [2:0] a, input logic [7:0] d);
        step_t s;
        s.kind = SK_WRITE;
        s.addr = a;
        s.data = d;
        s.wsel = WT_VDD;
        return s;
    endfunction

    function automatic step_t mk_other(input step_kind_e k, input wait_sel_e w,
                                       input logic [7:0] d);
        step_t s;
        s.kind = k;
        s.addr = 3'd0;
        s.data = d;
        s.wsel = w;
        return s;
    endfunction

endpackage

// File: rtl/lcd_seq_values.sv
`timescale 1ns/1ps
module lcd_seq_values #(
    parameter int DEF_BIAS   = 125,
    parameter int QVGA_PHASE = 9
) (
    input  logic       qvga,
    input  logic [3:0] phase_adj,
    input  logic       phase_unset,
    input  logic [7:0] bias_val,
    input  logic       bias_unset,
    output logic [7:0] phase_byte,
    output logic [7:0] bias_byte
);
    localparam logic [3:0] QVGA_NIB = 4'(QVGA_PHASE);
    localparam logic [7:0] DEF_B    = 8'(DEF_BIAS);

    // Bit 0 selects manual phase; the adjustment sits one bit up.
    always_comb begin
        if (qvga)
            phase_byte = {3'b000, QVGA_NIB, 1'b1};
        else if (phase_unset)
            phase_byte = 8'h01;
        else
            phase_byte = {3'b000, phase_adj, 1'b1};
    end

    assign bias_byte = bias_unset ? DEF_B : bias_val;

endmodule

// File: rtl/lcd_seq_program.sv
`timescale 1ns/1ps
module lcd_seq_program
    import lcd_seq_pkg::*;
(
    input  seq_sel_e                sel,
    input  logic [STEP_IDX_W-1:0]   idx,
    input  logic                    qvga,
    input  logic [7:0]              phase_byte,
    input  logic [7:0]              bias_byte,
    output step_t                   step
);
    logic [7:0] res_byte;
    assign res_byte = {7'd0, qvga};

    always_comb begin
        step = mk_other(SK_END, WT_VDD, 8'h00);
        unique case (sel)
            SQ_FULL: begin
                unique case (idx)
                    5'd0:  step = mk_wr(ADR_IFCTL, 8'h1F);
                    5'd1:  step = mk_wr(ADR_PWR0,  8'h03);
                    5'd2:  step = mk_wr(ADR_PWR1,  8'h00);
                    5'd3:  step = mk_wr(ADR_PWR1,  8'h04);
                    5'd4:  step = mk_other(SK_WAIT, WT_VDD, 8'h00);
                    5'd5:  step = mk_wr(ADR_PWR0,  8'h07);
                    5'd6:  step = mk_wr(ADR_IFCTL, 8'h09);
                    5'd7:  step = mk_other(SK_DAC, WT_VDD, bias_byte);
                    5'd8:  step = mk_wr(ADR_PWR0,  8'h17);
                    5'd9:  step = mk_wr(ADR_PWR1,  8'h06);
                    5'd10: step = mk_other(SK_WAIT, WT_GVSS, 8'h00);
                    5'd11: step = mk_wr(ADR_IFCTL, 8'h01);
                    5'd12: step = mk_wr(ADR_PWR0,  8'h1F);
                    5'd13: step = mk_wr(ADR_PWR1,  8'h07);
                    5'd14: step = mk_wr(ADR_IFCTL, 8'h00);
                    5'd15: step = mk_wr(ADR_PHASE, phase_byte);
                    5'd16: step = mk_wr(ADR_POL,   8'h00);
                    5'd17: step = mk_other(SK_WAIT, WT_SETTLE, 8'h00);
                    5'd18: step = mk_other(SK_SETF, WT_VDD, 8'h00);
                    5'd19: step = mk_wr(ADR_RES,   res_byte);
                    default: step = mk_other(SK_END, WT_VDD, 8'h00);
                endcase
            end
            SQ_QUICK: begin
                unique case (idx)
                    5'd0:  step = mk_wr(ADR_PHASE, phase_byte);
                    5'd1:  step = mk_wr(ADR_RES,   res_byte);
                    default: step = mk_other(SK_END, WT_VDD, 8'h00);
                endcase
            end
            SQ_DOWN: begin
                unique case (idx)
                    5'd0:  step = mk_other(SK_WAIT, WT_FRAME, 8'h00);
                    5'd1:  step = mk_wr(ADR_PWR1,  8'h06);
                    5'd2:  step = mk_wr(ADR_IFCTL, 8'h08);
                    5'd3:  step = mk_wr(ADR_PWR0,  8'h14);
                    5'd4:  step = mk_other(SK_DAC, WT_VDD, 8'h00);
                    5'd5:  step = mk_wr(ADR_PWR1,  8'h04);
                    5'd6:  step = mk_wr(ADR_PWR0,  8'h04);
                    5'd7:  step = mk_wr(ADR_IFCTL, 8'h1E);
                    5'd8:  step = mk_wr(ADR_PWR0,  8'h00);
                    5'd9:  step = mk_wr(ADR_PWR1,  8'h00);
                    5'd10: step = mk_other(SK_CLRF, WT_VDD, 8'h00);
                    default: step = mk_other(SK_END, WT_VDD, 8'h00);
                endcase
            end
            default: step = mk_other(SK_END, WT_VDD, 8'h00);
        endcase
    end

endmodule

// File: rtl/lcd_seq_timer.sv
`timescale 1ns/1ps
module lcd_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt > CNT_W'(1))
            cnt <= cnt - CNT_W'(1);
    end

    // Expires on the load_val-th cycle of run.
    assign expired = run && (cnt <= CNT_W'(1));

endmodule

// File: rtl/lcd_pwr_seq.sv
`timescale 1ns/1ps
module lcd_pwr_seq
    import lcd_seq_pkg::*;
#(
    parameter int T_VDD_CYC    = 300000,
    parameter int T_GVSS_CYC   = 200000,
    parameter int T_SETTLE_CYC = 100000,
    parameter int T_FRAME_CYC  = 3400000,
    parameter int DEF_BIAS     = 125,
    parameter int QVGA_PHASE   = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_up_req,
    input  logic       up_mode_qvga,
    input  logic       suspend_req,
    input  logic [3:0] phase_adj,
    input  logic       phase_unset,
    input  logic [7:0] bias_val,
    input  logic       bias_unset,
    output logic       reg_wr_valid,
    output logic [2:0] reg_wr_addr,
    output logic [7:0] reg_wr_data,
    input  logic       reg_wr_ready,
    output logic       dac_start,
    output logic [7:0] dac_value,
    input  logic       dac_done,
    output logic       panel_init,
    output logic       seq_busy,
    output logic       seq_done
);
    localparam int T_MAX_A = (T_VDD_CYC > T_GVSS_CYC) ? T_VDD_CYC : T_GVSS_CYC;
    localparam int T_MAX_B = (T_SETTLE_CYC > T_FRAME_CYC) ? T_SETTLE_CYC : T_FRAME_CYC;
    localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int CNT_W   = $clog2(T_MAX + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_WR_WAIT,
        ST_DELAY,
        ST_DAC_WAIT,
        ST_DONE
    } state_e;

    state_e                  state, state_nx;
    seq_sel_e                sel_q;
    logic [STEP_IDX_W-1:0]   idx_q;
    logic                    qvga_q, phu_q, biasu_q, init_q;
    logic [3:0]              ph_q;
    logic [7:0]              bias_q;
    logic [7:0]              phase_byte, bias_byte;
    step_t                   step;
    logic                    advance, accept, t_load, t_expired;
    logic [CNT_W-1:0]        t_val;

    lcd_seq_values #(
        .DEF_BIAS   (DEF_BIAS),
        .QVGA_PHASE (QVGA_PHASE)
    ) u_values (
        .qvga        (qvga_q),
        .phase_adj   (ph_q),
        .phase_unset (phu_q),
        .bias_val    (bias_q),
        .bias_unset  (biasu_q),
        .phase_byte  (phase_byte),
        .bias_byte   (bias_byte)
    );

    lcd_seq_program u_program (
        .sel        (sel_q),
        .idx        (idx_q),
        .qvga       (qvga_q),
        .phase_byte (phase_byte),
        .bias_byte  (bias_byte),
        .step       (step)
    );

    always_comb begin
        unique case (step.wsel)
            WT_VDD:    t_val = CNT_W'(T_VDD_CYC);
            WT_GVSS:   t_val = CNT_W'(T_GVSS_CYC);
            WT_SETTLE: t_val = CNT_W'(T_SETTLE_CYC);
            WT_FRAME:  t_val = CNT_W'(T_FRAME_CYC);
            default:   t_val = CNT_W'(T_VDD_CYC);
        endcase
    end

    assign t_load = (state == ST_STEP) && (step.kind == SK_WAIT);

    lcd_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .run      (state == ST_DELAY),
        .expired  (t_expired)
    );

    assign accept = (state == ST_IDLE) && (pwr_up_req || suspend_req);

    // Next-state logic
    always_comb begin
        state_nx = state;
        advance  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept)
                    state_nx = ST_STEP;
            end
            ST_STEP: begin
                unique case (step.kind)
                    SK_WRITE: state_nx = ST_WR_WAIT;
                    SK_WAIT:  state_nx = ST_DELAY;
                    SK_DAC:   state_nx = ST_DAC_WAIT;
                    SK_SETF,
                    SK_CLRF:  advance  = 1'b1;
                    SK_END:   state_nx = ST_DONE;
                    default:  state_nx = ST_DONE;
                endcase
            end
            ST_WR_WAIT: begin
                if (reg_wr_ready) begin
                    state_nx = ST_STEP;
                    advance  = 1'b1;
                end
            end
            ST_DELAY: begin
                if (t_expired) begin
                    state_nx = ST_STEP;
                    advance  = 1'b1;
                end
            end
            ST_DAC_WAIT: begin
                if (dac_done) begin
                    state_nx = ST_STEP;
                    advance  = 1'b1;
                end
            end
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Step pointer, request capture and the initialized flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= SQ_FULL;
            idx_q   <= '0;
            qvga_q  <= 1'b0;
            ph_q    <= 4'd0;
            phu_q   <= 1'b1;
            bias_q  <= 8'd0;
            biasu_q <= 1'b1;
            init_q  <= 1'b0;
        end else begin
            if (accept) begin
                idx_q   <= '0;
                sel_q   <= suspend_req ? SQ_DOWN : (init_q ? SQ_QUICK : SQ_FULL);
                qvga_q  <= up_mode_qvga;
                ph_q    <= phase_adj;
                phu_q   <= phase_unset;
                bias_q  <= bias_val;
                biasu_q <= bias_unset;
            end else if (advance) begin
                idx_q <= idx_q + STEP_IDX_W'(1);
            end
            if (state == ST_STEP && step.kind == SK_SETF)
                init_q <= 1'b1;
            else if (state == ST_STEP && step.kind == SK_CLRF)
                init_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        reg_wr_valid = (state == ST_STEP) && (step.kind == SK_WRITE);
        reg_wr_addr  = step.addr;
        reg_wr_data  = step.data;
        dac_start    = (state == ST_STEP) && (step.kind == SK_DAC);
        dac_value    = step.data;
        panel_init   = init_q;
        seq_busy     = (state != ST_IDLE);
        seq_done     = (state == ST_DONE);
    end

endmodule

// File: rtl/lcd_pwr_seq_chk.sv
`timescale 1ns/1ps
module lcd_pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_valid,
    input logic       reg_wr_ready,
    input logic       dac_start,
    input logic [7:0] dac_value,
    input logic       dac_done,
    input logic       panel_init,
    input logic       seq_busy,
    input logic       seq_done
);
    logic wr_pend, dac_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_pend  <= 1'b0;
            dac_pend <= 1'b0;
        end else begin
            if (reg_wr_valid)      wr_pend <= 1'b1;
            else if (reg_wr_ready) wr_pend <= 1'b0;
            if (dac_start)         dac_pend <= 1'b1;
            else if (dac_done)     dac_pend <= 1'b0;
        end
    end

    // R10
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_valid |=> !reg_wr_valid);

    // R10
    wr_wait_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |-> !reg_wr_valid);

    // R4
    dac_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_start |=> !dac_start);

    // R4
    dac_value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_pend |-> $stable(dac_value));

    // R11
    wr_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_valid || dac_start) |-> seq_busy);

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (!seq_done && !seq_busy));

    // R9
    init_rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(panel_init) |-> seq_busy);

    // R9
    init_fall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(panel_init) |-> seq_busy);

endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_valid (reg_wr_valid),
    .reg_wr_ready (reg_wr_ready),
    .dac_start    (dac_start),
    .dac_value    (dac_value),
    .dac_done     (dac_done),
    .panel_init   (panel_init),
    .seq_busy     (seq_busy),
    .seq_done     (seq_done)
);

// File: tb/lcd_pwr_seq_test.sv
`timescale 1ns/1ps
module lcd_pwr_seq_test;
    localparam int TV = 30, TG = 20, TS = 10, TF = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_up_req = 1'b0, up_mode_qvga = 1'b0, suspend_req = 1'b0;
    logic [3:0] phase_adj = 4'd0;
    logic       phase_unset = 1'b1;
    logic [7:0] bias_val = 8'd0;
    logic       bias_unset = 1'b1;
    logic       reg_wr_valid, reg_wr_ready = 1'b0;
    logic [2:0] reg_wr_addr;
    logic [7:0] reg_wr_data, dac_value;
    logic       dac_start, dac_done = 1'b0;
    logic       panel_init, seq_busy, seq_done;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int got_a[64], got_d[64], got_c[64], got_i[64];
    int got_n = 0, dac_n = 0, dac_v = 0, done_n = 0;
    int exp_a[64], exp_d[64];
    int exp_n = 0, exp_dac = 0;
    bit model_init = 1'b0;

    lcd_pwr_seq #(
        .T_VDD_CYC(TV), .T_GVSS_CYC(TG), .T_SETTLE_CYC(TS), .T_FRAME_CYC(TF)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pwr_up_req(pwr_up_req), .up_mode_qvga(up_mode_qvga),
        .suspend_req(suspend_req), .phase_adj(phase_adj), .phase_unset(phase_unset),
        .bias_val(bias_val), .bias_unset(bias_unset), .reg_wr_valid(reg_wr_valid),
        .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data), .reg_wr_ready(reg_wr_ready),
        .dac_start(dac_start), .dac_value(dac_value), .dac_done(dac_done),
        .panel_init(panel_init), .seq_busy(seq_busy), .seq_done(seq_done)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor
    always @(negedge clk) begin
        if (reg_wr_valid && got_n < 64) begin
            got_a[got_n] = int'(reg_wr_addr);
            got_d[got_n] = int'(reg_wr_data);
            got_c[got_n] = cyc;
            got_i[got_n] = int'(panel_init);
            got_n = got_n + 1;
        end
        if (dac_start) begin
            dac_n = dac_n + 1;
            dac_v = int'(dac_value);
        end
        if (seq_done) done_n = done_n + 1;
    end

    // Register port responder
    initial begin
        forever begin
            @(negedge clk);
            while (reg_wr_valid) begin
                repeat (($urandom % 3) + 1) @(negedge clk);
                reg_wr_ready = 1'b1;
                @(negedge clk);
                reg_wr_ready = 1'b0;
            end
        end
    end

    // DAC responder
    initial begin
        forever begin
            @(negedge clk);
            while (dac_start) begin
                repeat (($urandom % 5) + 1) @(negedge clk);
                dac_done = 1'b1;
                @(negedge clk);
                dac_done = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int f_phase(bit q, bit [3:0] p, bit pu);
        if (q) return 8'h13;
        if (pu) return 8'h01;
        return {3'b000, p, 1'b1};
    endfunction

    function automatic int f_bias(bit [7:0] b, bit bu);
        return bu ? 125 : int'(b);
    endfunction

    task automatic push(input int a, input int d);
        exp_a[exp_n] = a;
        exp_d[exp_n] = d;
        exp_n++;
    endtask

    // kind: 0 full power-up, 1 quick power-up, 2 suspend
    task automatic build_exp(input int kind, input bit q, input bit [3:0] p, input bit pu,
                             input bit [7:0] b, input bit bu);
        exp_n = 0;
        if (kind == 0) begin
            push(6, 8'h1F); push(3, 8'h03); push(4, 8'h00); push(4, 8'h04);
            push(3, 8'h07); push(6, 8'h09); push(3, 8'h17); push(4, 8'h06);
            push(6, 8'h01); push(3, 8'h1F); push(4, 8'h07); push(6, 8'h00);
            push(1, f_phase(q, p, pu)); push(7, 0); push(0, int'(q));
            exp_dac = f_bias(b, bu);
        end else if (kind == 1) begin
            push(1, f_phase(q, p, pu)); push(0, int'(q));
        end else begin
            push(4, 8'h06); push(6, 8'h08); push(3, 8'h14); push(4, 8'h04);
            push(3, 8'h04); push(6, 8'h1E); push(3, 8'h00); push(4, 8'h00);
            exp_dac = 0;
        end
    endtask

    function automatic string wr_req(int kind, int a);
        if (kind != 2 && a == 1) return "R5";
        if (kind != 2 && a == 0) return "R6";
        if (kind == 0) return "R2";
        if (kind == 1) return "R7";
        return "R8";
    endfunction

    // req: 0 power-up, 1 suspend, 2 both at once
    task automatic run(input int req, input bit q, input bit [3:0] p, input bit pu,
                       input bit [7:0] b, input bit bu, input bit disturb);
        int kind, req_c, lim;
        kind = (req != 0) ? 2 : (model_init ? 1 : 0);
        build_exp(kind, q, p, pu, b, bu);
        got_n = 0; dac_n = 0; done_n = 0;
        @(negedge clk);
        up_mode_qvga = q; phase_adj = p; phase_unset = pu; bias_val = b; bias_unset = bu;
        pwr_up_req  = (req != 1);
        suspend_req = (req != 0);
        req_c = cyc;
        @(negedge clk);
        pwr_up_req = 1'b0; suspend_req = 1'b0;
        chk(seq_busy == 1'b1, "R12", "busy after request", int'(seq_busy), 1);
        if (disturb) begin
            repeat (($urandom % 20) + 3) @(negedge clk);
            pwr_up_req = 1'b1; suspend_req = 1'b1; up_mode_qvga = ~q;
            @(negedge clk);
            pwr_up_req = 1'b0; suspend_req = 1'b0;
        end
        lim = 0;
        while (done_n == 0 && lim < 5000) begin
            @(negedge clk);
            lim++;
        end
        repeat (5) @(negedge clk);
        chk(done_n == 1, "R12", "done pulse count", done_n, 1);
        chk(seq_busy == 1'b0, "R11", "idle after sequence", int'(seq_busy), 0);
        chk(got_n == exp_n, wr_req(kind, 3), "write count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            chk(got_a[i] == exp_a[i] && got_d[i] == exp_d[i], wr_req(kind, exp_a[i]),
                $sformatf("write %0d addr/data", i),
                (got_a[i] << 8) | got_d[i], (exp_a[i] << 8) | exp_d[i]);
        if (kind == 1) begin
            chk(dac_n == 0, "R7", "no bias step", dac_n, 0);
        end else begin
            chk(dac_n == 1, "R4", "bias step count", dac_n, 1);
            chk(dac_v == exp_dac, "R4", "bias value", dac_v, exp_dac);
        end
        if (kind == 0 && got_n == 15) begin
            chk(got_c[4] - got_c[3] >= TV, "R3", "VDD delay", got_c[4] - got_c[3], TV);
            chk(got_c[8] - got_c[7] >= TG, "R3", "GVSS delay", got_c[8] - got_c[7], TG);
            chk(got_c[14] - got_c[13] >= TS, "R3", "settle delay", got_c[14] - got_c[13], TS);
            chk(got_i[13] == 0 && got_i[14] == 1, "R9", "flag around resolution write",
                (got_i[13] << 4) | got_i[14], 1);
        end
        if (kind == 2 && got_n > 0) begin
            chk(got_c[0] - req_c >= TF, "R3", "frame delay", got_c[0] - req_c, TF);
            chk(got_i[got_n-1] == int'(model_init), "R9", "flag held until end",
                got_i[got_n-1], int'(model_init));
        end
        model_init = (kind != 2);
        chk(panel_init == model_init, "R9", "flag after sequence", int'(panel_init), int'(model_init));
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        chk(seq_busy == 0 && panel_init == 0 && reg_wr_valid == 0 && dac_start == 0 && seq_done == 0,
            "R1", "reset state",
            {27'd0, seq_busy, panel_init, reg_wr_valid, dac_start, seq_done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // full power-up VGA, nothing stored
        run(0, 1'b0, 4'h3, 1'b1, 8'h00, 1'b1, 1'b0);
        // quick path QVGA, then VGA with a stored phase
        run(0, 1'b1, 4'hA, 1'b0, 8'h10, 1'b0, 1'b0);
        run(0, 1'b0, 4'hA, 1'b0, 8'h10, 1'b0, 1'b0);
        run(1, 1'b0, 4'h0, 1'b1, 8'h00, 1'b1, 1'b0);
        // full power-up QVGA with stored bias and requests injected while busy
        run(0, 1'b1, 4'h5, 1'b0, 8'h40, 1'b0, 1'b1);
        // both requests at once while idle: suspend wins (R11)
        run(2, 1'b0, 4'h0, 1'b1, 8'h00, 1'b1, 1'b0);
        for (int k = 0; k < 6; k++) begin
            run(0, 1'($urandom), 4'($urandom), 1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
            if (($urandom % 2) == 0)
                run(0, 1'($urandom), 4'($urandom), 1'($urandom), 8'($urandom), 1'($urandom), 1'b0);
            run(1, 1'b0, 4'h0, 1'b1, 8'h00, 1'b1, 1'($urandom));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule